// File: doc/BRIEF.md
# Integer ALU with Per-Instruction Flag Rules

This block is the integer execution stage of a two-operand, accumulator-style processor. Each cycle it takes an opcode, a destination operand, a source operand and a size select, and produces the new destination value together with a write-enable for it. Four status flags are kept in a register inside the block: sign, zero, overflow and carry. When an instruction is presented, the block updates only the flags that the instruction's rule allows and leaves the rest as they were.

The result path is purely combinational from the inputs and the current carry flag. The flags are written on the rising clock edge at which `op_valid` is high. In byte mode the arithmetic and the flags use only bits 7:0. The upper 24 bits of the destination then pass through unchanged. Add-with-carry and subtract-with-borrow read the carry flag held at the moment the instruction is presented, so chains of these instructions can be built across several cycles for wide arithmetic.

Top module: `alu_flagged`

## Requirements
- R1: Opcode encoding is ADD=0, ADC=1, SUB=2, SBB=3, CMP=4, AND=5, OR=6, XOR=7, TEST=8, INC=9, DEC=10, NEG=11, NOT=12, CLC=13, STC=14, CMC=15. ADD gives dst+src and ADC gives dst+src+C. SUB gives dst-src and SBB gives dst-src-C. Each of these asserts `result_we`.
- R2: ADD, ADC, SUB, SBB and CMP update all four flags. S is the result's top bit and Z is set when the result is zero. C is the carry out for additions and the borrow for subtractions. O is set for addition when the operands' signs match and the result's sign differs from them. O is set for subtraction when the operands' signs differ and the result's sign differs from dst.
- R3: AND, OR and XOR write the bitwise result, set S and Z from it, and clear O and C.
- R4: CMP and TEST update flags as SUB and AND would, but keep `result_we` low.
- R5: INC and DEC write dst+1 and dst-1 and update S, Z and O by the addition/subtraction rule. C keeps its prior value.
- R6: NEG writes 0-dst and updates all four flags. C is 1 exactly when dst is nonzero.
- R7: NOT writes the bitwise complement of dst and leaves all four flags unchanged.
- R8: CLC clears C, STC sets C and CMC inverts C. S, Z and O are unchanged and `result_we` is low.
- R9: With `byte_mode` high, the result bits 7:0 and all flags come from 8-bit arithmetic, and result bits 31:8 equal dst bits 31:8.
- R10: While `op_valid` is low, `result_we` is low and no flag changes.
- R11: Synchronous reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 4 | Operation select (encoding in R1) |
| byte_mode | input | 1 | 1: 8-bit operation, 0: 32-bit operation |
| dst_val | input | 32 | Destination operand (also the single operand of INC/DEC/NEG/NOT) |
| src_val | input | 32 | Source operand |
| result | output | 32 | New destination value |
| result_we | output | 1 | Destination write-enable |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
Operand pairs are chosen at the signed and unsigned wrap points: the largest positive value plus one, all ones plus one, the smallest negative value minus one, and equal operands. Each pair separates carry from overflow and sets zero without sign. The carry is preset both ways before ADC, SBB, INC, DEC and the logic operations. This shows whether the carry is consumed, preserved or forced to zero. The byte-mode pairs are ones whose 8-bit and 32-bit answers disagree in zero, carry or sign, so a wrong lane choice is visible. NEG is tried on zero, on a small positive value and on the most negative value.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_TEST = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_NEG  = 4'd11,
        OP_NOT  = 4'd12,
        OP_CLC  = 4'd13,
        OP_STC  = 4'd14,
        OP_CMC  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        K_NONE, K_ARITH, K_AND, K_OR, K_XOR, K_NOT
    } kind_e;

    typedef enum logic [1:0] { O_KEEP, O_CALC, O_ZERO } o_mode_e;

    typedef enum logic [2:0] { C_KEEP, C_CALC, C_ZERO, C_ONE, C_FLIP } c_mode_e;

    typedef struct packed {
        logic s;
        logic z;
        logic o;
        logic c;
    } flags_t;

    typedef struct packed {
        kind_e   kind;
        logic    sub;
        logic    use_cin;
        logic    a_zero;
        logic    b_one;
        logic    b_dst;
        logic    wr;
        logic    upd_sz;
        o_mode_e o_mode;
        c_mode_e c_mode;
    } ctrl_t;

    function automatic ctrl_t decode(input alu_op_e op);
        ctrl_t c;
        c = '{kind: K_NONE, sub: 1'b0, use_cin: 1'b0, a_zero: 1'b0,
              b_one: 1'b0, b_dst: 1'b0, wr: 1'b0, upd_sz: 1'b0,
              o_mode: O_KEEP, c_mode: C_KEEP};
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                c.kind    = K_ARITH;
                c.sub     = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
                c.use_cin = (op == OP_ADC) || (op == OP_SBB);
                c.wr      = (op != OP_CMP);
                c.upd_sz  = 1'b1;
                c.o_mode  = O_CALC;
                c.c_mode  = C_CALC;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                c.kind   = (op == OP_OR)  ? K_OR  :
                           (op == OP_XOR) ? K_XOR : K_AND;
                c.wr     = (op != OP_TEST);
                c.upd_sz = 1'b1;
                c.o_mode = O_ZERO;
                c.c_mode = C_ZERO;
            end
            OP_INC, OP_DEC: begin
                c.kind   = K_ARITH;
                c.sub    = (op == OP_DEC);
                c.b_one  = 1'b1;
                c.wr     = 1'b1;
                c.upd_sz = 1'b1;
                c.o_mode = O_CALC;
            end
            OP_NEG: begin
                c.kind   = K_ARITH;
                c.sub    = 1'b1;
                c.a_zero = 1'b1;
                c.b_dst  = 1'b1;
                c.wr     = 1'b1;
                c.upd_sz = 1'b1;
                c.o_mode = O_CALC;
                c.c_mode = C_CALC;
            end
            OP_NOT: begin
                c.kind = K_NOT;
                c.wr   = 1'b1;
            end
            OP_CLC:  c.c_mode = C_ZERO;
            OP_STC:  c.c_mode = C_ONE;
            default: c.c_mode = C_FLIP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    always_comb begin
        if (sub)
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        if (sub)
            ovf = (a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
        else
            ovf = ~(a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    upd_sz,
    input  o_mode_e o_mode,
    input  c_mode_e c_mode,
    input  flags_t  calc,
    output flags_t  cur
);
    flags_t nxt;

    always_comb begin
        nxt = cur;
        if (upd_sz) begin
            nxt.s = calc.s;
            nxt.z = calc.z;
        end
        case (o_mode)
            O_CALC:  nxt.o = calc.o;
            O_ZERO:  nxt.o = 1'b0;
            default: nxt.o = cur.o;
        endcase
        case (c_mode)
            C_CALC:  nxt.c = calc.c;
            C_ZERO:  nxt.c = 1'b0;
            C_ONE:   nxt.c = 1'b1;
            C_FLIP:  nxt.c = ~cur.c;
            default: nxt.c = cur.c;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (en)
            cur <= nxt;
    end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_o,
    output logic              flag_c
);
    localparam int HI_W = DATA_W - BYTE_W;

    ctrl_t             ctrl;
    flags_t            cur;
    flags_t            calc;
    logic [DATA_W-1:0] a_op, b_op, logic_val;
    logic              cin;

    logic [DATA_W-1:0] sum_w;
    logic              cout_w, ovf_w;
    logic [BYTE_W-1:0] sum_b;
    logic              cout_b, ovf_b;
    logic [DATA_W-1:0] lane_w;
    logic [BYTE_W-1:0] lane_b;

    assign ctrl = decode(alu_op_e'(op_code));
    assign a_op = ctrl.a_zero ? '0 : dst_val;
    assign b_op = ctrl.b_one ? DATA_W'(1) : (ctrl.b_dst ? dst_val : src_val);
    assign cin  = ctrl.use_cin & cur.c;

    alu_addsub #(.W(DATA_W)) i_add_word (
        .a(a_op), .b(b_op), .cin(cin), .sub(ctrl.sub),
        .sum(sum_w), .cout(cout_w), .ovf(ovf_w)
    );

    alu_addsub #(.W(BYTE_W)) i_add_byte (
        .a(a_op[BYTE_W-1:0]), .b(b_op[BYTE_W-1:0]), .cin(cin), .sub(ctrl.sub),
        .sum(sum_b), .cout(cout_b), .ovf(ovf_b)
    );

    always_comb begin
        case (ctrl.kind)
            K_AND:   logic_val = dst_val & src_val;
            K_OR:    logic_val = dst_val | src_val;
            K_XOR:   logic_val = dst_val ^ src_val;
            K_NOT:   logic_val = ~dst_val;
            default: logic_val = dst_val;
        endcase
        lane_w = (ctrl.kind == K_ARITH) ? sum_w : logic_val;
        lane_b = (ctrl.kind == K_ARITH) ? sum_b : logic_val[BYTE_W-1:0];

        if (byte_mode) begin
            result = {dst_val[DATA_W-1 -: HI_W], lane_b};
            calc.s = lane_b[BYTE_W-1];
            calc.z = (lane_b == '0);
            calc.o = ovf_b;
            calc.c = cout_b;
        end else begin
            result = lane_w;
            calc.s = lane_w[DATA_W-1];
            calc.z = (lane_w == '0);
            calc.o = ovf_w;
            calc.c = cout_w;
        end
    end

    assign result_we = op_valid & ctrl.wr;

    alu_flag_reg i_flags (
        .clk(clk), .rst(rst), .en(op_valid),
        .upd_sz(ctrl.upd_sz), .o_mode(ctrl.o_mode), .c_mode(ctrl.c_mode),
        .calc(calc), .cur(cur)
    );

    assign flag_s = cur.s;
    assign flag_z = cur.z;
    assign flag_o = cur.o;
    assign flag_c = cur.c;
endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic              byte_mode,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic              flag_s,
    input logic              flag_z,
    input logic              flag_o,
    input logic              flag_c
);
    logic [3:0] fl;
    assign fl = {flag_s, flag_z, flag_o, flag_c};

    logic is_logic;
    assign is_logic = op_valid && (op_code == OP_AND || op_code == OP_OR ||
                                   op_code == OP_XOR || op_code == OP_TEST);

    assert_logic_clears_oc_R3: assert property (@(posedge clk) disable iff (rst)
        is_logic |=> (!flag_o && !flag_c));

    assert_cmp_test_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_CMP || op_code == OP_TEST)) |-> !result_we);

    assert_incdec_keep_c_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> (flag_c == $past(flag_c)));

    assert_not_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_NOT) |=> $stable(fl));

    assert_clc_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CLC) |=> !flag_c);

    assert_stc_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_STC) |=> flag_c);

    assert_cmc_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMC) |=> (flag_c != $past(flag_c)));

    assert_byte_upper_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (result_we && byte_mode) |-> (result[DATA_W-1:BYTE_W] == dst_val[DATA_W-1:BYTE_W]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(fl));

    assert_idle_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !result_we);
endmodule

bind alu_flagged alu_checker i_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .dst_val(dst_val), .result(result),
    .result_we(result_we), .flag_s(flag_s), .flag_z(flag_z),
    .flag_o(flag_o), .flag_c(flag_c)
);

// File: tb/test_alu_flagged.sv
module test_alu_flagged;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic [31:0] result;
    logic        result_we;
    logic        flag_s, flag_z, flag_o, flag_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    alu_flagged i_alu_flagged (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .dst_val(dst_val), .src_val(src_val),
        .result(result), .result_we(result_we),
        .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o), .flag_c(flag_c)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        byt;
        logic [31:0] d;
        logic [31:0] s;
        logic        cin;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;   // {S,Z,O,C}
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{OP_ADD,  1'b0, 32'h7FFFFFFF, 32'h1,        1'b0, 32'h80000000, 1'b1, 4'b1010},
        '{OP_ADD,  1'b0, 32'hFFFFFFFF, 32'h1,        1'b0, 32'h00000000, 1'b1, 4'b0101},
        '{OP_ADC,  1'b0, 32'h5,        32'h3,        1'b1, 32'h00000009, 1'b1, 4'b0000},
        '{OP_SUB,  1'b0, 32'h3,        32'h5,        1'b0, 32'hFFFFFFFE, 1'b1, 4'b1001},
        '{OP_SBB,  1'b0, 32'hA,        32'h3,        1'b1, 32'h00000006, 1'b1, 4'b0000},
        '{OP_SUB,  1'b0, 32'h80000000, 32'h1,        1'b0, 32'h7FFFFFFF, 1'b1, 4'b0010},
        '{OP_CMP,  1'b0, 32'h7,        32'h7,        1'b1, 32'h0,        1'b0, 4'b0100},
        '{OP_AND,  1'b0, 32'hF0F0F0F0, 32'h80FF0000, 1'b1, 32'h80F00000, 1'b1, 4'b1000},
        '{OP_OR,   1'b0, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 4'b0100},
        '{OP_XOR,  1'b0, 32'h12345678, 32'h12345678, 1'b1, 32'h00000000, 1'b1, 4'b0100},
        '{OP_TEST, 1'b0, 32'h80000000, 32'h80000000, 1'b1, 32'h0,        1'b0, 4'b1000},
        '{OP_INC,  1'b0, 32'h7FFFFFFF, 32'h0,        1'b1, 32'h80000000, 1'b1, 4'b1011},
        '{OP_DEC,  1'b0, 32'h1,        32'h0,        1'b0, 32'h00000000, 1'b1, 4'b0100},
        '{OP_DEC,  1'b0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 1'b1, 4'b1001},
        '{OP_NEG,  1'b0, 32'h5,        32'h0,        1'b0, 32'hFFFFFFFB, 1'b1, 4'b1001},
        '{OP_NEG,  1'b0, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 4'b0100},
        '{OP_NEG,  1'b0, 32'h80000000, 32'h0,        1'b0, 32'h80000000, 1'b1, 4'b1011},
        '{OP_ADD,  1'b1, 32'hAABBCC7F, 32'h1,        1'b0, 32'hAABBCC80, 1'b1, 4'b1010},
        '{OP_ADD,  1'b1, 32'h123456FF, 32'h1,        1'b0, 32'h12345600, 1'b1, 4'b0101},
        '{OP_SUB,  1'b1, 32'hFFFFFF00, 32'h1,        1'b0, 32'hFFFFFFFF, 1'b1, 4'b1001},
        '{OP_INC,  1'b1, 32'h556677FF, 32'h0,        1'b0, 32'h55667700, 1'b1, 4'b0100},
        '{OP_NEG,  1'b1, 32'hDEADBE01, 32'h0,        1'b0, 32'hDEADBEFF, 1'b1, 4'b1001},
        '{OP_XOR,  1'b1, 32'h9900FF80, 32'h12340000, 1'b1, 32'h9900FF80, 1'b1, 4'b1000}
    };

    function automatic string req_of(input logic [3:0] op, input logic byt);
        if (byt) return "R9";
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: return "R1/R2";
            OP_CMP, OP_TEST:                return "R4";
            OP_AND, OP_OR, OP_XOR:          return "R3";
            OP_INC, OP_DEC:                 return "R5";
            OP_NEG:                         return "R6";
            default:                        return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic present(input logic [3:0] op, input logic byt,
                           input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        op_valid  = 1'b1;
        op_code   = op;
        byte_mode = byt;
        dst_val   = d;
        src_val   = s;
        #1;
    endtask

    task automatic finish_op;
        @(posedge clk);
        #1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic preset_c(input logic c);
        present(c ? OP_STC : OP_CLC, 1'b0, '0, '0);
        finish_op();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] saved;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check("R11", "flags after reset", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h0);
        check("R10", "we while idle", {31'd0, result_we}, 32'h0);

        // Vector table: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            preset_c(VECS[i].cin);
            present(VECS[i].op, VECS[i].byt, VECS[i].d, VECS[i].s);
            if (VECS[i].we)
                check(req_of(VECS[i].op, VECS[i].byt), $sformatf("result v%0d", i),
                      result, VECS[i].res);
            check(req_of(VECS[i].op, VECS[i].byt), $sformatf("we v%0d", i),
                  {31'd0, result_we}, {31'd0, VECS[i].we});
            @(posedge clk);
            #1;
            check(req_of(VECS[i].op, VECS[i].byt), $sformatf("flags v%0d", i),
                  {28'd0, flag_s, flag_z, flag_o, flag_c}, {28'd0, VECS[i].fl});
            @(negedge clk);
            op_valid = 1'b0;
        end

        // R7: NOT complements and keeps flags (flags now 1001 from last vector? recompute)
        present(OP_SUB, 1'b0, 32'h80000000, 32'h1);   // flags -> 0010
        finish_op();
        preset_c(1'b1);                               // flags -> 0011
        saved = {flag_s, flag_z, flag_o, flag_c};
        check("R8", "STC keeps S Z O", {28'd0, saved}, 32'h3);
        present(OP_NOT, 1'b0, 32'h0F0F0F0F, 32'h0);
        check("R7", "NOT result", result, 32'hF0F0F0F0);
        check("R7", "NOT we", {31'd0, result_we}, 32'h1);
        finish_op();
        check("R7", "NOT flags", {28'd0, flag_s, flag_z, flag_o, flag_c}, {28'd0, saved});

        // R8: CMC twice, CLC
        present(OP_CMC, 1'b0, 32'h0, 32'h0);
        check("R8", "CMC we", {31'd0, result_we}, 32'h0);
        finish_op();
        check("R8", "CMC from 1", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h2);
        present(OP_CMC, 1'b0, 32'h0, 32'h0);
        finish_op();
        check("R8", "CMC from 0", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h3);
        present(OP_CLC, 1'b0, 32'h0, 32'h0);
        finish_op();
        check("R8", "CLC", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h2);

        // R10: instruction inputs with op_valid low change nothing
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = OP_ADD;
        dst_val  = 32'hFFFFFFFF;
        src_val  = 32'h1;
        #1;
        check("R10", "we low when not valid", {31'd0, result_we}, 32'h0);
        repeat (2) @(posedge clk);
        #1;
        check("R10", "flags held when not valid", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h2);

        // R11: reset mid-run clears flags
        preset_c(1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11", "flags after second reset", {28'd0, flag_s, flag_z, flag_o, flag_c}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule